// File: doc/BRIEF.md
# Host-to-Processor Receive Mailbox

This block carries one 24-bit word from a host to a processor. The host loads the word into three byte lanes. Lane 2 is the high byte, lane 1 the middle byte and lane 0 the low byte, and each lane has its own write strobe. A write to the low lane arms the transfer. When the host-side transmit-empty flag and the processor-side receive-full flag are both clear, the assembled word moves into a receive register. The processor can only read that register. The transfer sets both flags again.

The processor watches receive-full, or takes a maskable interrupt request, and then reads the word. The read clears receive-full, so the next host word can move across. A read while receive-full is already clear does not change the flags or the data. It raises a sticky error bit.

Four reset sources each leave their own mix of state behind:
- a hardware reset;
- a software reset;
- an individual reset, held while the port-enable input is low;
- a stop reset.

Top module: `hrx_mailbox`

## Requirements
- R1: On a transfer, `rx_data` takes {lane 2, lane 1, lane 0}, where lane 2 is bits 23:16 and lane 0 is bits 7:0. `rx_data` changes at no other time except a hardware reset.
- R2: A write to lane 0 (`host_wr[0]`) clears `tx_empty` at that clock edge. Writes to lanes 1 and 2 alone leave `tx_empty` unchanged.
- R3: A cycle with `tx_empty`=0, `rx_full`=0 and no reset active causes a transfer at the next edge. The transfer sets both `tx_empty` and `rx_full` to 1. At most one transfer happens per clock.
- R4: While `rx_full`=1 no transfer happens. `rx_data` and `tx_empty` hold, unless the host writes lane 0 again.
- R5: A `proc_rd` pulse while `rx_full`=1 clears `rx_full` at that edge.
- R6: `rx_irq` is registered and equals `irq_en` AND `rx_full`, where `irq_en` is loaded from `ie_wdata` when `ie_wr` is high outside a reset.
- R7: A `proc_rd` while `rx_full`=0 sets the sticky `rd_err`. It leaves `rx_data` and both flags as they would be without the read.
- R8: Hardware reset (`rst`) gives `tx_empty`=1, `rx_full`=0, `irq_en`=0, `rd_err`=0, `rx_irq`=0, `rx_data`=0 and clears all host lanes.
- R9: Software reset (`sw_rst`) gives `tx_empty`=1, `rx_full`=0, `irq_en`=0 and `rd_err`=0. It keeps `rx_data` and the host lanes.
- R10: Individual reset (`port_en`=0, every cycle it is low) gives `tx_empty`=1, `rx_full`=0 and `irq_en`=0. It keeps `rd_err`, `rx_data` and the host lanes.
- R11: Stop reset (`stop_rst`) gives `tx_empty`=1 and `rx_full`=0. It keeps `irq_en`, `rd_err`, `rx_data` and the host lanes.
- R12: Reset priority is hardware, then software, then individual, then stop. In any reset cycle, reads, lane-0 arming and `ie_wr` have no effect on the flags. Host lane writes still land, except during a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| port_en | input | 1 | Port enable; low holds the individual reset |
| stop_rst | input | 1 | Stop reset, synchronous, active high |
| host_wr | input | 3 | Per-lane host write strobes, bit 0 = low lane |
| host_wdata | input | 8 | Host byte written to every strobed lane |
| proc_rd | input | 1 | Processor read of the receive register |
| ie_wr | input | 1 | Load interrupt enable |
| ie_wdata | input | 1 | Interrupt enable value |
| rx_data | output | 24 | Receive register |
| rx_full | output | 1 | Receive-full flag (processor side) |
| tx_empty | output | 1 | Transmit-empty flag (host side) |
| rx_irq | output | 1 | Receive interrupt request |
| rd_err | output | 1 | Sticky read-while-empty error |

## Verification
A flag stuck in the wrong state shows up at the ports within one or two clocks, in one of three ways:
- a transfer is lost;
- a transfer is duplicated, so a second word overwrites an unread one;
- `rx_data` changes while `rx_full` stays high.

A corrupted lane shows up as a wrong `rx_data` value on the edge after the transfer condition. A reset that restores the wrong set of state shows up first in `rx_irq` or `rd_err`. For example, a stop reset that clears the enable is seen on the next transfer, when `rx_irq` stays low. The bench compares every output against a behavioural model on every clock, so each such fault is seen on the first cycle it shows.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_STOP,
    RK_PORT,
    RK_SOFT,
    RK_HARD
  } rst_kind_e;

  // Priority: hardware, software, individual, stop
  function automatic rst_kind_e decode_rst(input logic hw, input logic sw,
                                           input logic en, input logic stp);
    if (hw)        return RK_HARD;
    else if (sw)   return RK_SOFT;
    else if (!en)  return RK_PORT;
    else if (stp)  return RK_STOP;
    else           return RK_NONE;
  endfunction

endpackage

// File: rtl/hrx_host_lanes.sv
module hrx_host_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  wr,
  input  logic [LANE_W-1:0] wdata,
  output logic [WORD_W-1:0] word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)        lane_q <= '0;
      else if (wr[i]) lane_q <= wdata;
    end
    assign word[i*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/hrx_flag_ctrl.sv
module hrx_flag_ctrl
  import hrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_rst,
  input  logic port_en,
  input  logic stop_rst,
  input  logic arm_wr,
  input  logic proc_rd,
  input  logic ie_wr,
  input  logic ie_wdata,
  output logic load,
  output logic tx_empty,
  output logic rx_full,
  output logic irq_en,
  output logic rx_irq,
  output logic rd_err
);

  rst_kind_e kind;
  logic txe_d, rxf_d, ie_d, err_d;

  always_comb kind = decode_rst(rst, sw_rst, port_en, stop_rst);

  assign load = (kind == RK_NONE) && !tx_empty && !rx_full;

  always_comb begin
    txe_d = tx_empty;
    rxf_d = rx_full;
    ie_d  = irq_en;
    err_d = rd_err;
    case (kind)
      RK_HARD: begin txe_d = 1'b1; rxf_d = 1'b0; ie_d = 1'b0; err_d = 1'b0; end
      RK_SOFT: begin txe_d = 1'b1; rxf_d = 1'b0; ie_d = 1'b0; err_d = 1'b0; end
      RK_PORT: begin txe_d = 1'b1; rxf_d = 1'b0; ie_d = 1'b0; end
      RK_STOP: begin txe_d = 1'b1; rxf_d = 1'b0; end
      default: begin
        if (load) begin
          txe_d = 1'b1;
          rxf_d = 1'b1;
        end
        if (proc_rd) begin
          if (rx_full) rxf_d = 1'b0;
          else         err_d = 1'b1;
        end
        if (arm_wr) txe_d = 1'b0;
        if (ie_wr)  ie_d  = ie_wdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    tx_empty <= txe_d;
    rx_full  <= rxf_d;
    irq_en   <= ie_d;
    rd_err   <= err_d;
    rx_irq   <= ie_d & rxf_d;
  end

endmodule

// File: rtl/hrx_rx_reg.sv
module hrx_rx_reg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/hrx_mailbox.sv
module hrx_mailbox #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              port_en,
  input  logic              stop_rst,
  input  logic [LANES-1:0]  host_wr,
  input  logic [LANE_W-1:0] host_wdata,
  input  logic              proc_rd,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              rx_irq,
  output logic              rd_err
);

  logic [WORD_W-1:0] host_word;
  logic              load;
  logic              irq_en;

  hrx_host_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .clk   (clk),
    .rst   (rst),
    .wr    (host_wr),
    .wdata (host_wdata),
    .word  (host_word)
  );

  hrx_flag_ctrl u_flags (
    .clk      (clk),
    .rst      (rst),
    .sw_rst   (sw_rst),
    .port_en  (port_en),
    .stop_rst (stop_rst),
    .arm_wr   (host_wr[0]),
    .proc_rd  (proc_rd),
    .ie_wr    (ie_wr),
    .ie_wdata (ie_wdata),
    .load     (load),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .irq_en   (irq_en),
    .rx_irq   (rx_irq),
    .rd_err   (rd_err)
  );

  hrx_rx_reg #(.WORD_W(WORD_W)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (host_word),
    .dout (rx_data)
  );

endmodule

// File: rtl/hrx_mailbox_chk.sv
module hrx_mailbox_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_rst,
  input logic              port_en,
  input logic              stop_rst,
  input logic              lo_wr,
  input logic              proc_rd,
  input logic              irq_en,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_full,
  input logic              tx_empty,
  input logic              rx_irq,
  input logic              rd_err
);

  logic quiet;
  assign quiet = !sw_rst && port_en && !stop_rst;

  // R3
  transfer_sets_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && !tx_empty && !rx_full && !lo_wr) |=> (tx_empty && rx_full));

  // R4
  full_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && rx_full) |=> $stable(rx_data));

  // R5
  read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && rx_full && proc_rd) |=> !rx_full);

  // R6
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_full && irq_en));

  // R7
  empty_read_err_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && !rx_full && proc_rd) |=> rd_err);

  // R8
  hw_reset_state_chk: assert property (@(posedge clk)
    rst |=> (tx_empty && !rx_full && !rd_err && !rx_irq && rx_data == '0));

  // R11
  stop_keeps_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_rst && port_en && stop_rst && rd_err) |=> (rd_err && !rx_full));

endmodule

bind hrx_mailbox hrx_mailbox_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sw_rst   (sw_rst),
  .port_en  (port_en),
  .stop_rst (stop_rst),
  .lo_wr    (host_wr[0]),
  .proc_rd  (proc_rd),
  .irq_en   (irq_en),
  .rx_data  (rx_data),
  .rx_full  (rx_full),
  .tx_empty (tx_empty),
  .rx_irq   (rx_irq),
  .rd_err   (rd_err)
);

// File: tb/hrx_mailbox_tb_top.sv
module hrx_mailbox_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        port_en = 1'b1;
  logic        stop_rst = 1'b0;
  logic [2:0]  host_wr = '0;
  logic [7:0]  host_wdata = '0;
  logic        proc_rd = 1'b0;
  logic        ie_wr = 1'b0;
  logic        ie_wdata = 1'b0;
  logic [23:0] rx_data;
  logic        rx_full, tx_empty, rx_irq, rd_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  hrx_mailbox dut_i (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .port_en(port_en),
    .stop_rst(stop_rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .proc_rd(proc_rd), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .rx_data(rx_data), .rx_full(rx_full), .tx_empty(tx_empty),
    .rx_irq(rx_irq), .rd_err(rd_err)
  );

  // Behavioural reference model
  int m_lane[3];
  int m_data, m_txe, m_rxf, m_ie, m_err, m_irq;

  always @(posedge clk) begin
    int o_txe, o_rxf, word;
    o_txe = m_txe;
    o_rxf = m_rxf;
    word = (m_lane[2] << 16) | (m_lane[1] << 8) | m_lane[0];
    if (rst) begin
      foreach (m_lane[k]) m_lane[k] = 0;
      m_data = 0; m_txe = 1; m_rxf = 0; m_ie = 0; m_err = 0;
    end else begin
      for (int k = 0; k < 3; k++) if (host_wr[k]) m_lane[k] = host_wdata;
      if (sw_rst) begin
        m_txe = 1; m_rxf = 0; m_ie = 0; m_err = 0;
      end else if (!port_en) begin
        m_txe = 1; m_rxf = 0; m_ie = 0;
      end else if (stop_rst) begin
        m_txe = 1; m_rxf = 0;
      end else begin
        if (o_txe == 0 && o_rxf == 0) begin
          m_data = word; m_txe = 1; m_rxf = 1;
        end
        if (proc_rd) begin
          if (o_rxf == 1) m_rxf = 0;
          else m_err = 1;
        end
        if (host_wr[0]) m_txe = 0;
        if (ie_wr) m_ie = ie_wdata;
      end
    end
    m_irq = m_ie & m_rxf;
    cmp_on = 1;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    check("R1 rx_data", int'(rx_data), m_data);
    check("R3 tx_empty", int'(tx_empty), m_txe);
    check("R5 rx_full", int'(rx_full), m_rxf);
    check("R6 rx_irq", int'(rx_irq), m_irq);
    check("R7 rd_err", int'(rd_err), m_err);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    host_wr = '0; proc_rd = 0; ie_wr = 0; sw_rst = 0; stop_rst = 0;
    port_en = 1; rst = 0;
  endtask

  task automatic put_word(logic [23:0] w);
    host_wr = 3'b111; host_wdata = w[23:16];
    host_wr = 3'b100; tick();
    host_wr = 3'b010; host_wdata = w[15:8]; tick();
    host_wr = 3'b001; host_wdata = w[7:0]; tick();
    host_wr = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    idle();
    // R8: reset state
    check("R8 tx_empty after reset", int'(tx_empty), 1);
    check("R8 rx_full after reset", int'(rx_full), 0);
    check("R8 rx_data after reset", int'(rx_data), 0);

    // R2: upper lanes alone do not arm
    host_wr = 3'b110; host_wdata = 8'h5A; tick(); host_wr = 0; tick();
    check("R2 upper lanes keep tx_empty", int'(tx_empty), 1);

    // R1/R3: full word transfer
    put_word(24'hA5C33C);
    check("R2 lane0 write clears tx_empty", int'(tx_empty), 0);
    tick();
    check("R3 transfer sets rx_full", int'(rx_full), 1);
    check("R3 transfer sets tx_empty", int'(tx_empty), 1);
    check("R1 word order", int'(rx_data), 24'hA5C33C);

    // R4: second word waits while full
    put_word(24'h112233);
    tick(3);
    check("R4 data held while full", int'(rx_data), 24'hA5C33C);
    check("R4 tx_empty stays low", int'(tx_empty), 0);

    // R6: enable interrupt
    ie_wr = 1; ie_wdata = 1; tick(); ie_wr = 0;
    check("R6 irq with enable and full", int'(rx_irq), 1);

    // R5: read clears, pending word follows one clock later
    proc_rd = 1; tick(); proc_rd = 0;
    check("R5 read clears rx_full", int'(rx_full), 0);
    check("R6 irq drops with rx_full", int'(rx_irq), 0);
    tick();
    check("R3 pending word moves", int'(rx_data), 24'h112233);

    // R7: read while empty
    proc_rd = 1; tick(); proc_rd = 0;
    proc_rd = 1; tick(); proc_rd = 0;
    check("R7 sticky error", int'(rd_err), 1);
    check("R7 data unchanged", int'(rx_data), 24'h112233);
    check("R7 rx_full unchanged", int'(rx_full), 0);

    // R11: stop reset keeps enable and error
    put_word(24'h0F0F0F);
    stop_rst = 1; tick(); stop_rst = 0;
    check("R11 stop clears tx_empty to 1", int'(tx_empty), 1);
    check("R11 stop keeps rd_err", int'(rd_err), 1);
    put_word(24'h778899); tick();
    check("R11 stop keeps enable", int'(rx_irq), 1);

    // R10: individual reset
    port_en = 0; tick(2); port_en = 1;
    check("R10 keeps rd_err", int'(rd_err), 1);
    check("R10 keeps rx_data", int'(rx_data), 24'h778899);
    put_word(24'h010203); tick();
    check("R10 clears enable", int'(rx_irq), 0);

    // R9: software reset
    sw_rst = 1; tick(); sw_rst = 0;
    check("R9 clears rd_err", int'(rd_err), 0);
    check("R9 keeps rx_data", int'(rx_data), 24'h010203);

    // R12: priority and ignored actions in reset cycles
    ie_wr = 1; ie_wdata = 1; proc_rd = 1; stop_rst = 1; sw_rst = 1; tick();
    idle();
    check("R12 soft beats stop, err stays clear", int'(rd_err), 0);
    put_word(24'h4455AA); tick();
    check("R12 enable write ignored in reset", int'(rx_irq), 0);

    // R8: hardware reset clears data
    rst = 1; tick(); rst = 0;
    check("R8 hw clears rx_data", int'(rx_data), 0);

    // Random phase, compared against the model every clock
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 199);
      rst = (r == 0);
      sw_rst = (r == 1);
      port_en = !(r == 2 || r == 3);
      stop_rst = (r == 4);
      host_wr = 3'($urandom);
      host_wdata = 8'($urandom);
      proc_rd = ($urandom_range(0, 3) == 0);
      ie_wr = ($urandom_range(0, 15) == 0);
      ie_wdata = 1'($urandom);
      tick();
    end
    idle();
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule